// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block holds a small set of address translations, each keyed by a virtual page number together with a process identifier. Every lookup compares the requested key against all stored entries at once. One clock edge later the block reports a hit with the physical frame, the protection bits and the modified bit, or a miss, or a protection fault. The result is a one-cycle response. Because every entry carries its owner's process tag, a context switch does not require flushing the whole cache.

After a miss, the surrounding logic fetches the translation and writes it through the refill port. The block chooses which slot receives the new entry. It takes the lowest-numbered empty slot if there is one. Once every slot is occupied, a round-robin pointer picks the slot to overwrite. The cache can be emptied completely with one input. A second input drops only the entries that belong to one process.

The response path is a small state machine whose state register holds the outcome of the previous cycle's lookup. It has four named states:
- `S_IDLE`: no request was made.
- `S_HIT`: a permitted match.
- `S_MISS`: no matching valid entry.
- `S_FAULT`: a match whose protection forbids the access.

Every state can move to any state on each clock edge. When `lk_req` is low the next state is `S_IDLE`. When `lk_req` is high the next state is:
- `S_HIT` for a permitted match;
- `S_FAULT` for a match with a protection violation;
- `S_MISS` when nothing matches.

Top module: `xlat_cache`

## Requirements
- R1: After reset, no entry is valid, all response outputs are 0, and the first lookup of any key reports a miss.
- R2: A lookup whose page number and process identifier both equal those of a valid entry reports a hit and returns that entry's frame and protection bits.
- R3: A lookup whose page number matches a valid entry but whose process identifier differs reports a miss with frame 0.
- R4: Exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` is high in the cycle after a cycle with `lk_req` high. None of them is high after a cycle without a request.
- R5: The protection field has two bits. Bit 0 set permits writes, and bit 1 set permits user-mode access. A matching lookup that writes without bit 0, or that is a user access without bit 1, reports `rsp_fault` instead of a hit. In that case the frame and modified outputs read 0.
- R6: A permitted write hit sets that entry's modified bit, and `rsp_dirty` shows the bit as it stands after the access. A read hit leaves the bit unchanged, and a faulting write does not set it.
- R7: A refill writes the lowest-numbered invalid slot when one exists, leaves the round-robin pointer unchanged, and starts the new entry with its modified bit clear.
- R8: When all slots are valid, a refill overwrites the slot named by a round-robin pointer. The pointer starts at 0 and advances by one after each such eviction, wrapping after the last slot.
- R9: `flush_all` invalidates every entry at the next clock edge.
- R10: `flush_pid_en` invalidates exactly those entries whose process tag equals `flush_pid`, and leaves all other entries usable.
- R11: A lookup presented in the same cycle as a flush or refill is answered from the contents held before that clock edge. `flush_all` takes priority over `flush_pid_en`, which takes priority over a refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Lookup is a user-mode access |
| lk_pid | input | PID_W | Process identifier of the lookup |
| lk_vpn | input | VPN_W | Virtual page number of the lookup |
| rsp_hit | output | 1 | Previous lookup hit with permission |
| rsp_miss | output | 1 | Previous lookup found no entry |
| rsp_fault | output | 1 | Previous lookup violated protection |
| rsp_pfn | output | PFN_W | Frame of the hit, else 0 |
| rsp_prot | output | 2 | Protection bits of the hit, else 0 |
| rsp_dirty | output | 1 | Modified bit of the hit after the access |
| fill_en | input | 1 | Write a new translation |
| fill_pid | input | PID_W | Process tag of the new entry |
| fill_vpn | input | VPN_W | Page number of the new entry |
| fill_pfn | input | PFN_W | Frame of the new entry |
| fill_prot | input | 2 | Protection bits of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the entries of one process |
| flush_pid | input | PID_W | Process whose entries are invalidated |

## Verification
The assertions assume that the key presented by a refill is never already present among the valid entries. Under that assumption at most one slot can match a lookup, and the hit index encoding is meaningful. The bench respects this by giving each refill a page number, or a page number and process pair, that is not currently valid. It only reuses a key after that key has been flushed or evicted. It also never raises a refill in the same cycle as a flush, so the pointer-hold property sees only refills that actually write.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    // protection field bit positions
    localparam int PROT_W   = 2;
    localparam int PROT_WR  = 0;
    localparam int PROT_USR = 1;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_HIT   = 2'd1,
        S_MISS  = 2'd2,
        S_FAULT = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ENTRIES-1:0]              vld,
    input  logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab,
    input  logic [ENTRIES-1:0][PID_W-1:0]   pid_tab,
    input  logic [VPN_W-1:0]                key_vpn,
    input  logic [PID_W-1:0]                key_pid,
    output logic                            any_hit,
    output logic [IDX_W-1:0]                hit_idx
);
    logic [ENTRIES-1:0] hit_vec;

    // one comparator per slot, all evaluated together
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (vpn_tab[g] == key_vpn)
                                   && (pid_tab[g] == key_pid);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign any_hit = |hit_vec;

    // refill keys are unique, so a lookup can match at most one slot
    p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld,
    input  logic               fill_take,
    output logic [IDX_W-1:0]   vic_idx
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             full;

    assign full = &vld;

    // lowest invalid slot: scan downward so the smallest index wins
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) free_idx = IDX_W'(i);
        end
    end

    assign vic_idx = full ? rr_ptr : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_take && full) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && !full) |=> $stable(rr_ptr));
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_take && full && rr_ptr != IDX_W'(ENTRIES - 1))
            |=> (rr_ptr == $past(rr_ptr) + 1'b1));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic              lk_write,
    input  logic              lk_user,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [1:0]        rsp_prot,
    output logic              rsp_dirty,
    input  logic              fill_en,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_prot,
    input  logic              flush_all,
    input  logic              flush_pid_en,
    input  logic [PID_W-1:0]  flush_pid
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]              vld;
    logic [ENTRIES-1:0]              dirty;
    logic [ENTRIES-1:0][VPN_W-1:0]   vpn_tab;
    logic [ENTRIES-1:0][PID_W-1:0]   pid_tab;
    logic [ENTRIES-1:0][PFN_W-1:0]   pfn_tab;
    logic [ENTRIES-1:0][PROT_W-1:0]  prot_tab;

    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] vic_idx;
    logic             fill_take;
    logic             perm_bad;
    logic             wr_ok;

    rsp_state_t state_q, state_d;
    logic [PFN_W-1:0]  pfn_q;
    logic [PROT_W-1:0] prot_q;
    logic              dirty_q;

    xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_match (
        .clk(clk), .rst_n(rst_n), .vld(vld), .vpn_tab(vpn_tab),
        .pid_tab(pid_tab), .key_vpn(lk_vpn), .key_pid(lk_pid),
        .any_hit(any_hit), .hit_idx(hit_idx)
    );

    assign fill_take = fill_en && !flush_all && !flush_pid_en;

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .vld(vld), .fill_take(fill_take),
        .vic_idx(vic_idx)
    );

    assign perm_bad = (lk_write && !prot_tab[hit_idx][PROT_WR]) ||
                      (lk_user  && !prot_tab[hit_idx][PROT_USR]);
    assign wr_ok    = lk_req && lk_write && any_hit && !perm_bad;

    // entry storage: flush_all > flush by process > refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld   <= '0;
            dirty <= '0;
        end else if (flush_all) begin
            vld <= '0;
        end else begin
            if (wr_ok) dirty[hit_idx] <= 1'b1;
            if (flush_pid_en) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (pid_tab[i] == flush_pid) vld[i] <= 1'b0;
                end
            end else if (fill_en) begin
                vld[vic_idx]      <= 1'b1;
                dirty[vic_idx]    <= 1'b0;
                vpn_tab[vic_idx]  <= fill_vpn;
                pid_tab[vic_idx]  <= fill_pid;
                pfn_tab[vic_idx]  <= fill_pfn;
                prot_tab[vic_idx] <= fill_prot;
            end
        end
    end

    // response state machine: next-state logic
    always_comb begin
        state_d = S_IDLE;
        if (lk_req) begin
            if (!any_hit)     state_d = S_MISS;
            else if (perm_bad) state_d = S_FAULT;
            else              state_d = S_HIT;
        end
    end

    // state register with the data captured alongside it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            pfn_q   <= '0;
            prot_q  <= '0;
            dirty_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == S_HIT) begin
                pfn_q   <= pfn_tab[hit_idx];
                prot_q  <= prot_tab[hit_idx];
                dirty_q <= dirty[hit_idx] | lk_write;
            end else begin
                pfn_q   <= '0;
                prot_q  <= '0;
                dirty_q <= 1'b0;
            end
        end
    end

    // outputs decoded from the state
    always_comb begin
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_HIT:   rsp_hit   = 1'b1;
            S_MISS:  rsp_miss  = 1'b1;
            S_FAULT: rsp_fault = 1'b1;
        endcase
        rsp_pfn   = pfn_q;
        rsp_prot  = prot_q;
        rsp_dirty = dirty_q;
    end

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> (rsp_hit || rsp_miss || rsp_fault));
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit || rsp_miss || rsp_fault) |-> $past(lk_req));
    p_fault_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_pfn == '0 && !rsp_dirty));
    p_dirty_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (rsp_hit && rsp_dirty));
    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (vld == '0));
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
    localparam int ENTRIES = 64;
    localparam int VPN_W = 20, PFN_W = 20, PID_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_req = 0, lk_write = 0, lk_user = 0;
    logic [PID_W-1:0] lk_pid = '0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [PFN_W-1:0] rsp_pfn;
    logic [1:0] rsp_prot;
    logic fill_en = 0;
    logic [PID_W-1:0] fill_pid = '0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [1:0] fill_prot = '0;
    logic flush_all = 0, flush_pid_en = 0;
    logic [PID_W-1:0] flush_pid = '0;

    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .PID_W(PID_W)) u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_write(lk_write),
        .lk_user(lk_user), .lk_pid(lk_pid), .lk_vpn(lk_vpn),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
        .rsp_pfn(rsp_pfn), .rsp_prot(rsp_prot), .rsp_dirty(rsp_dirty),
        .fill_en(fill_en), .fill_pid(fill_pid), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_prot(fill_prot), .flush_all(flush_all),
        .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // result code: 1 hit, 2 miss, 3 fault, 0 none
    function automatic logic [31:0] code();
        return {29'd0, rsp_fault, rsp_miss, rsp_hit} == 32'd1 ? 32'd1 :
               {29'd0, rsp_fault, rsp_miss, rsp_hit} == 32'd2 ? 32'd2 :
               {29'd0, rsp_fault, rsp_miss, rsp_hit} == 32'd4 ? 32'd3 :
               {29'd0, rsp_fault, rsp_miss, rsp_hit} == 32'd0 ? 32'd0 : 32'hBAD;
    endfunction

    task automatic look(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                        input logic w, input logic u);
        @(negedge clk);
        lk_req = 1; lk_pid = p; lk_vpn = v; lk_write = w; lk_user = u;
        @(posedge clk);
        @(negedge clk);
        lk_req = 0; lk_write = 0; lk_user = 0;
    endtask

    task automatic fill(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                        input logic [PFN_W-1:0] f, input logic [1:0] pr);
        @(negedge clk);
        fill_en = 1; fill_pid = p; fill_vpn = v; fill_pfn = f; fill_prot = pr;
        @(posedge clk);
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic expect_hit(input string tag, input logic [PID_W-1:0] p,
                              input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] f);
        look(p, v, 0, 0);
        chk({tag, " hit"}, code(), 1);
        chk({tag, " pfn"}, 32'(rsp_pfn), 32'(f));
    endtask

    task automatic expect_miss(input string tag, input logic [PID_W-1:0] p,
                               input logic [VPN_W-1:0] v);
        look(p, v, 0, 0);
        chk({tag, " miss"}, code(), 2);
        chk({tag, " pfn0"}, 32'(rsp_pfn), 0);
    endtask

    task automatic t_reset;
        chk("R1 idle after reset", code(), 0);
        chk("R1 pfn after reset", 32'(rsp_pfn), 0);
        expect_miss("R1 first lookup", 8'd1, 20'h100);
    endtask

    task automatic t_basic;
        fill(8'd1, 20'h100, 20'hAAA, 2'b11);
        expect_hit("R2 key match", 8'd1, 20'h100, 20'hAAA);
        chk("R2 prot", 32'(rsp_prot), 3);
        expect_miss("R3 other pid", 8'd2, 20'h100);
        expect_miss("R3 other vpn", 8'd1, 20'h101);
        @(negedge clk);
        chk("R4 no response without request", code(), 0);
    endtask

    task automatic t_prot;
        fill(8'd1, 20'h200, 20'hBBB, 2'b00);
        look(8'd1, 20'h200, 1, 0);
        chk("R5 write to read-only faults", code(), 3);
        chk("R5 fault pfn zero", 32'(rsp_pfn), 0);
        look(8'd1, 20'h200, 0, 1);
        chk("R5 user on supervisor page faults", code(), 3);
        look(8'd1, 20'h200, 0, 0);
        chk("R5 supervisor read hits", code(), 1);
        fill(8'd1, 20'h300, 20'hCCC, 2'b10);
        look(8'd1, 20'h300, 0, 1);
        chk("R5 user read allowed", code(), 1);
        look(8'd1, 20'h300, 1, 1);
        chk("R5 user write no write bit", code(), 3);
    endtask

    task automatic t_dirty;
        look(8'd1, 20'h100, 0, 0);
        chk("R6 clean before write", 32'(rsp_dirty), 0);
        look(8'd1, 20'h100, 1, 1);
        chk("R6 write hit", code(), 1);
        chk("R6 dirty after write", 32'(rsp_dirty), 1);
        look(8'd1, 20'h100, 0, 0);
        chk("R6 dirty kept on read", 32'(rsp_dirty), 1);
        look(8'd1, 20'h200, 0, 0);
        chk("R6 faulting write left clean", 32'(rsp_dirty), 0);
    endtask

    task automatic t_flush;
        // lookup in the flush cycle sees old contents
        @(negedge clk);
        flush_all = 1; lk_req = 1; lk_pid = 8'd1; lk_vpn = 20'h100;
        @(posedge clk);
        @(negedge clk);
        flush_all = 0; lk_req = 0;
        chk("R11 lookup during flush hits", code(), 1);
        expect_miss("R9 after flush_all", 8'd1, 20'h100);
        expect_miss("R9 after flush_all b", 8'd1, 20'h300);
        fill(8'd1, 20'h500, 20'h111, 2'b11);
        fill(8'd2, 20'h600, 20'h222, 2'b11);
        @(negedge clk);
        flush_pid_en = 1; flush_pid = 8'd1;
        @(posedge clk);
        @(negedge clk);
        flush_pid_en = 0;
        expect_miss("R10 flushed pid", 8'd1, 20'h500);
        expect_hit("R10 other pid kept", 8'd2, 20'h600, 20'h222);
    endtask

    task automatic t_replace;
        @(negedge clk); flush_all = 1; @(posedge clk); @(negedge clk); flush_all = 0;
        for (int i = 0; i < ENTRIES; i++)
            fill((i % 4 == 3) ? 8'd5 : 8'd6, 20'h1000 + 20'(i), 20'h8000 + 20'(i), 2'b11);
        look(8'd6, 20'h1000, 0, 0);
        chk("R7 refill starts clean", 32'(rsp_dirty), 0);
        expect_hit("R8 full table last", 8'd5, 20'h1000 + 20'(ENTRIES - 1), 20'h8000 + 20'(ENTRIES - 1));
        fill(8'd7, 20'h2000, 20'h4000, 2'b11);
        expect_miss("R8 slot 0 evicted", 8'd6, 20'h1000);
        expect_hit("R8 new entry", 8'd7, 20'h2000, 20'h4000);
        expect_hit("R8 slot 1 kept", 8'd6, 20'h1001, 20'h8001);
        fill(8'd7, 20'h2001, 20'h4001, 2'b11);
        expect_miss("R8 slot 1 evicted next", 8'd6, 20'h1001);
        @(negedge clk);
        flush_pid_en = 1; flush_pid = 8'd5;
        @(posedge clk);
        @(negedge clk);
        flush_pid_en = 0;
        for (int k = 0; k < ENTRIES / 4; k++)
            fill(8'd8, 20'h3000 + 20'(k), 20'h5000 + 20'(k), 2'b11);
        expect_hit("R7 holes filled, rr slot 2 spared", 8'd6, 20'h1002, 20'h8002);
        expect_hit("R7 hole entry", 8'd8, 20'h3000, 20'h5000);
        fill(8'd9, 20'h4000, 20'h6000, 2'b11);
        expect_miss("R8 pointer resumes at slot 2", 8'd6, 20'h1002);
        expect_hit("R8 slot 4 kept", 8'd6, 20'h1004, 20'h8004);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_prot();
        t_dirty();
        t_flush();
        t_replace();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule